// File: doc/BRIEF.md
# Halt-Driven Power-State and Interrupt Controller

This block sits beside a low-power 8-bit processor and decides when the processor clock runs. A falling edge on the processor's active-low halt line stops the clock. The system then sleeps at one of two depths, chosen by whether a non-maskable interrupt was outstanding at the moment of the halt.

- **Snooze (light sleep):** entered when no non-maskable request is pending. Any maskable cause or any non-maskable event restarts the clock, and the maskable interrupt line then pulls the processor out of its halt.
- **Coma (deep sleep):** entered when the halt follows a non-maskable request. Only the reset button, the memory-slot flap closing, or a rising edge on the external sense input leaves it.

Every wake and interrupt cause is recorded in a sticky register that the processor reads and clears through I/O cycles. A second read location returns the synchronised level of the flap input.

The inactivity timer is reloaded from a port value whenever the keyboard scanner requests a scan. It raises a non-maskable request once, when it reaches zero.

The reset button works in two steps:
- A press while the clock is stopped only restarts the clock.
- A press while the clock is running drives the active-low reset output for a fixed number of cycles. The same press clears the cause register and the pending non-maskable request, and it reloads the timer.

The processor clock is nominally 3.2768 MHz. The controller itself runs on an always-on clock.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: After the synchronous reset the outputs are as follows: `pwr_state` = 0 (run), `cpu_clk_en` = 1, `int_n` = 1, `nmi_n` = 1, `rst_out_n` = 1, and the cause register reads 0.
- R2: In run state, a high-to-low change of `halt_n` with `nmi_n` high moves `pwr_state` to 1 (snooze) and drops `cpu_clk_en` to 0.
- R3: In snooze, a set maskable cause bit or a non-maskable event returns `pwr_state` to 0 with `cpu_clk_en` = 1. `int_n` is low exactly while cause bit 0 or bit 1 is set.
- R4: Address 0 reads the sticky cause register in bits 4:0, and bits 7:5 read 0. The bits are:
  - bit 0: keyboard-scan request
  - bit 1: battery low
  - bit 2: timer expiry
  - bit 3: flap rising edge
  - bit 4: sense rising edge
- R5: An I/O write to address 0 clears each cause bit written as 1 and leaves bits written as 0. A cause that arrives in the same cycle as its clear wins over the clear.
- R6: Outside coma, `nmi_n` goes low on timer expiry, on a flap rising edge or on a sense rising edge. It stays low until coma is entered or a run-state button reset occurs.
- R7: In run state, a high-to-low change of `halt_n` while `nmi_n` is low moves `pwr_state` to 2 (coma) with `cpu_clk_en` = 0, and releases `nmi_n`.
- R8: Coma ignores maskable causes and timer expiry. It returns to run only on a button press, a flap falling edge or a sense rising edge, and `nmi_n` stays high throughout.
- R9: A button press while `pwr_state` is 1 or 2 only restarts the clock. `rst_out_n` stays high.
- R10: A button press in run state holds `rst_out_n` low for `RST_LEN` cycles (default 8). It also clears the cause register and the pending non-maskable request.
- R11: The timer loads `tmo_reload` at reset, on `kbd_scan_req` and on a button reset. It then counts down once per cycle and flags expiry once, on reaching zero. A load value of 0 never expires.
- R12: Address 1 reads the synchronised flap level in bit 0 (1 = open). `io_rdata` is 0 whenever `io_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| halt_n | input | 1 | Processor halt, active low |
| kbd_scan_req | input | 1 | Keyboard-scan request pulse, synchronous |
| batt_low | input | 1 | Battery-low level, asynchronous |
| flap_open | input | 1 | Memory-slot flap level, 1 = open, asynchronous |
| sense_in | input | 1 | External sense input, asynchronous |
| btn_in | input | 1 | Reset button level, asynchronous |
| tmo_reload | input | TMO_W | Inactivity timer load value |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | ADDR_W | I/O register select |
| io_wdata | input | DATA_W | I/O write data |
| io_rdata | output | DATA_W | I/O read data |
| cpu_clk_en | output | 1 | Processor clock enable |
| int_n | output | 1 | Maskable interrupt, active low |
| nmi_n | output | 1 | Non-maskable interrupt, active low |
| rst_out_n | output | 1 | Processor reset, active low |
| pwr_state | output | 2 | 0 run, 1 snooze, 2 coma |

## Verification
The assertions assume the following about the block's inputs:
- `halt_n` and `kbd_scan_req` are already synchronous to `clk`.
- A button press lasts long enough to give a single synchronised rising edge.
- I/O strobes do not overlap the reset.

The stimulus drives every input half a cycle away from the active edge. Each press is held for several cycles before release. The asynchronous lines change only one at a time, with settling gaps, so every edge the assertions reason about appears exactly once after synchronisation.

// File: rtl/pwr_wake_pkg.sv
`timescale 1ns/1ps
// Package: shared power-state encoding and cause-bit positions for the
// power-state and interrupt controller. Assumes nothing beyond 1800-2017.
package pwr_wake_pkg;

    typedef enum logic [1:0] {
        PS_RUN    = 2'd0,
        PS_SNOOZE = 2'd1,
        PS_COMA   = 2'd2
    } pstate_t;

    localparam int CAUSE_W  = 5;
    localparam int CB_KBD   = 0;
    localparam int CB_BATT  = 1;
    localparam int CB_TMO   = 2;
    localparam int CB_FLAP  = 3;
    localparam int CB_SENSE = 4;

    // Cause bits that drive the maskable interrupt.
    localparam logic [CAUSE_W-1:0] MASKABLE = (CAUSE_W'(1) << CB_KBD) | (CAUSE_W'(1) << CB_BATT);

endpackage

// File: rtl/pwr_sync_edge.sv
`timescale 1ns/1ps
// Module: pwr_sync_edge
// Brings N asynchronous inputs into the clk domain through two flops each,
// then compares with a third flop to produce one-cycle rise/fall pulses.
// Assumes each input level is held for at least two clk cycles.
module pwr_sync_edge #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] level,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);

    logic [N-1:0] s1_q, s2_q, s3_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        // Per-bit synchroniser chain plus the history flop for edge detection.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1_q[i] <= 1'b0;
                s2_q[i] <= 1'b0;
                s3_q[i] <= 1'b0;
            end else begin
                s1_q[i] <= din[i];
                s2_q[i] <= s1_q[i];
                s3_q[i] <= s2_q[i];
            end
        end

        assign level[i] = s2_q[i];
        assign rise[i]  = s2_q[i] & ~s3_q[i];
        assign fall[i]  = ~s2_q[i] & s3_q[i];
    end

endmodule

// File: rtl/pwr_timeout.sv
`timescale 1ns/1ps
// Module: pwr_timeout
// Inactivity down-counter. Loads reload_val at reset or on reload, counts
// down once per cycle and flags expire for the single cycle it holds 1.
// A load value of zero leaves the counter idle.
module pwr_timeout #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             reload,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_q;

    // Load on reset or activity, otherwise count down until zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= reload_val;
        else if (reload)         cnt_q <= reload_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign expire = (cnt_q == CNT_W'(1)) && !reload;

    // R11: one expiry per load, never two cycles in a row.
    assert_single_expiry_R11: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !expire)
        else $error("timer expired twice in a row");

    // R11: an idle counter stays idle without a reload.
    assert_idle_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !reload) |=> (cnt_q == '0 && !expire))
        else $error("idle timer restarted by itself");

endmodule

// File: rtl/pwr_cause_reg.sv
`timescale 1ns/1ps
// Module: pwr_cause_reg
// Sticky interrupt-cause register with write-one-to-clear. A set arriving
// in the same cycle as a clear wins. sys_clr wipes all bits.
// Assumes set_vec bits are single-cycle or level events in the clk domain.
module pwr_cause_reg
    import pwr_wake_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAUSE_W-1:0] set_vec,
    input  logic               clr_wr,
    input  logic [CAUSE_W-1:0] clr_mask,
    input  logic               sys_clr,
    output logic [CAUSE_W-1:0] cause,
    output logic               int_req
);

    logic [CAUSE_W-1:0] eff_clr;

    assign eff_clr = clr_wr ? clr_mask : '0;

    // Accumulate causes; clear on write-one or system clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       cause <= '0;
        else if (sys_clr) cause <= '0;
        else              cause <= (cause & ~eff_clr) | set_vec;
    end

    assign int_req = |(cause & MASKABLE);

    // R4: without any clear, no set bit is ever lost.
    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sys_clr && !clr_wr) |=> ((cause & $past(cause)) == $past(cause)))
        else $error("cause bit dropped without a clear");

    // R5: a bit written as 1 with no coincident set reads 0 afterwards.
    assert_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !sys_clr) |=> ((cause & $past(clr_mask & ~set_vec)) == '0))
        else $error("write-one-to-clear left a bit set");

endmodule

// File: rtl/pwr_state_fsm.sv
`timescale 1ns/1ps
// Module: pwr_state_fsm
// Run/snooze/coma sequencer with the pending-NMI flag and the two-press
// reset pulse generator. halt_n is assumed synchronous to clk; all other
// event inputs are single-cycle pulses from the synchroniser.
module pwr_state_fsm
    import pwr_wake_pkg::*;
#(
    parameter int RST_LEN = 8
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    halt_n,
    input  logic    int_req,
    input  logic    nmi_src,
    input  logic    btn_rise,
    input  logic    flap_fall,
    input  logic    sense_rise,
    output pstate_t state,
    output logic    nmi_n,
    output logic    rst_out_n,
    output logic    sys_clr,
    output logic    cpu_clk_en
);

    localparam int RST_CW = $clog2(RST_LEN + 1);

    pstate_t           nxt;
    logic              halt_q;
    logic              halt_fall;
    logic              nmi_pend;
    logic [RST_CW-1:0] rst_cnt;
    logic              in_run;
    logic              wake_snooze;
    logic              wake_coma;

    assign in_run      = (state == PS_RUN);
    assign halt_fall   = halt_q & ~halt_n;
    assign sys_clr     = btn_rise & in_run;
    assign wake_snooze = btn_rise | int_req | nmi_pend | nmi_src;
    assign wake_coma   = btn_rise | flap_fall | sense_rise;

    // Remember the previous halt level so only a fresh halt puts the system to sleep.
    always_ff @(posedge clk) begin
        if (!rst_n) halt_q <= 1'b1;
        else        halt_q <= halt_n;
    end

    // Next-state selection for the three power states.
    always_comb begin
        nxt = state;
        unique case (state)
            PS_RUN: begin
                if (!sys_clr && halt_fall && rst_cnt == '0)
                    nxt = nmi_pend ? PS_COMA : PS_SNOOZE;
            end
            PS_SNOOZE: if (wake_snooze) nxt = PS_RUN;
            PS_COMA:   if (wake_coma)   nxt = PS_RUN;
            default:   nxt = PS_RUN;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PS_RUN;
        else        state <= nxt;
    end

    // Pending NMI: set by shutdown events outside coma, dropped on coma entry or button reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                          nmi_pend <= 1'b0;
        else if (sys_clr)                    nmi_pend <= 1'b0;
        else if (in_run && nxt == PS_COMA)   nmi_pend <= 1'b0;
        else if (nmi_src && state != PS_COMA) nmi_pend <= 1'b1;
    end

    // Reset pulse length counter, started by a run-state press.
    always_ff @(posedge clk) begin
        if (!rst_n)              rst_cnt <= '0;
        else if (sys_clr)        rst_cnt <= RST_CW'(RST_LEN);
        else if (rst_cnt != '0)  rst_cnt <= rst_cnt - 1'b1;
    end

    assign nmi_n      = ~nmi_pend;
    assign rst_out_n  = (rst_cnt == '0);
    assign cpu_clk_en = in_run;

    // R2: a fresh halt with no NMI outstanding enters snooze.
    assert_snooze_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && halt_fall && !nmi_pend && !btn_rise && rst_cnt == '0) |=> (state == PS_SNOOZE))
        else $error("halt did not enter snooze");

    // R3: a pending maskable cause wakes snooze on the next cycle.
    assert_snooze_wake_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_SNOOZE && int_req) |=> (state == PS_RUN))
        else $error("snooze not left on maskable cause");

    // R6: the NMI stays asserted until coma entry or a button reset.
    assert_nmi_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!nmi_n && !btn_rise && !(in_run && halt_fall)) |=> !nmi_n)
        else $error("NMI released early");

    // R7: a halt after an NMI enters coma and releases the NMI.
    assert_coma_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && halt_fall && nmi_pend && !btn_rise && rst_cnt == '0) |=> (state == PS_COMA && nmi_n))
        else $error("halt after NMI did not enter coma");

    // R8: coma holds without one of its three wake events.
    assert_coma_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_COMA && !btn_rise && !flap_fall && !sense_rise) |=> (state == PS_COMA))
        else $error("coma left without a wake event");

    // R9: no reset pulse is ever driven while the clock is stopped.
    assert_sleep_no_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != PS_RUN) |-> rst_out_n)
        else $error("reset driven while asleep");

    // R10: a run-state press starts the reset pulse on the next cycle.
    assert_reset_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sys_clr |=> !rst_out_n)
        else $error("reset pulse not started");

endmodule

// File: rtl/pwr_wake_ctrl.sv
`timescale 1ns/1ps
// Module: pwr_wake_ctrl (top)
// Power-state and interrupt controller: gates the processor clock on halt,
// chooses snooze or coma, raises INT/NMI, runs the inactivity timer and the
// two-press reset, and serves the cause and flap I/O reads.
// Assumes halt_n, kbd_scan_req and the I/O strobes are synchronous to clk.
module pwr_wake_ctrl
    import pwr_wake_pkg::*;
#(
    parameter int TMO_W   = 16,
    parameter int RST_LEN = 8,
    parameter int ADDR_W  = 1,
    parameter int DATA_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt_n,
    input  logic              kbd_scan_req,
    input  logic              batt_low,
    input  logic              flap_open,
    input  logic              sense_in,
    input  logic              btn_in,
    input  logic [TMO_W-1:0]  tmo_reload,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    output logic              cpu_clk_en,
    output logic              int_n,
    output logic              nmi_n,
    output logic              rst_out_n,
    output logic [1:0]        pwr_state
);

    localparam int                NSYNC      = 4;
    localparam int                SI_BATT    = 0;
    localparam int                SI_FLAP    = 1;
    localparam int                SI_SENSE   = 2;
    localparam int                SI_BTN     = 3;
    localparam logic [ADDR_W-1:0] CAUSE_ADDR = '0;
    localparam logic [ADDR_W-1:0] FLAP_ADDR  = ADDR_W'(1);

    logic [NSYNC-1:0]   s_lvl, s_rise, s_fall;
    logic               tmo_evt;
    logic               sys_clr;
    logic               int_req;
    logic               nmi_src;
    logic [CAUSE_W-1:0] cause;
    logic [CAUSE_W-1:0] set_vec;
    logic               clr_wr;
    pstate_t            state;
    logic               unused_bits;

    pwr_sync_edge #(.N(NSYNC)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({btn_in, sense_in, flap_open, batt_low}),
        .level (s_lvl),
        .rise  (s_rise),
        .fall  (s_fall)
    );

    pwr_timeout #(.CNT_W(TMO_W)) u_tmo (
        .clk        (clk),
        .rst_n      (rst_n),
        .reload_val (tmo_reload),
        .reload     (kbd_scan_req | sys_clr),
        .expire     (tmo_evt)
    );

    assign set_vec = {s_rise[SI_SENSE], s_rise[SI_FLAP], tmo_evt, s_lvl[SI_BATT], kbd_scan_req};
    assign clr_wr  = io_wr && (io_addr == CAUSE_ADDR);
    assign nmi_src = tmo_evt | s_rise[SI_FLAP] | s_rise[SI_SENSE];

    pwr_cause_reg u_cause (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .clr_wr   (clr_wr),
        .clr_mask (io_wdata[CAUSE_W-1:0]),
        .sys_clr  (sys_clr),
        .cause    (cause),
        .int_req  (int_req)
    );

    pwr_state_fsm #(.RST_LEN(RST_LEN)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .halt_n     (halt_n),
        .int_req    (int_req),
        .nmi_src    (nmi_src),
        .btn_rise   (s_rise[SI_BTN]),
        .flap_fall  (s_fall[SI_FLAP]),
        .sense_rise (s_rise[SI_SENSE]),
        .state      (state),
        .nmi_n      (nmi_n),
        .rst_out_n  (rst_out_n),
        .sys_clr    (sys_clr),
        .cpu_clk_en (cpu_clk_en)
    );

    // I/O read mux: cause register or flap level, zero when not reading.
    always_comb begin
        io_rdata = '0;
        if (io_rd) begin
            if (io_addr == CAUSE_ADDR)     io_rdata = DATA_W'(cause);
            else if (io_addr == FLAP_ADDR) io_rdata = DATA_W'(s_lvl[SI_FLAP]);
        end
    end

    assign int_n       = ~int_req;
    assign pwr_state   = state;
    assign unused_bits = ^{io_wdata[DATA_W-1:CAUSE_W], s_rise[SI_BATT], s_fall[SI_BATT],
                           s_fall[SI_SENSE], s_fall[SI_BTN], s_lvl[SI_SENSE], s_lvl[SI_BTN]};

    // R3: the maskable line tracks the maskable cause bits.
    assert_int_tracks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_n) == (cause[CB_KBD] | cause[CB_BATT]))
        else $error("int_n does not follow maskable causes");

    // R12: nothing is driven on the read bus outside a read.
    assert_rdata_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |-> (io_rdata == '0))
        else $error("read data driven without a read");

endmodule

// File: tb/pwr_wake_ctrl_bench.sv
`timescale 1ns/1ps
module pwr_wake_ctrl_bench;

    localparam real CLK_PERIOD = 5.0;
    localparam int  RST_LEN    = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        halt_n = 1'b1, kbd_scan_req = 1'b0, batt_low = 1'b0;
    logic        flap_open = 1'b0, sense_in = 1'b0, btn_in = 1'b0;
    logic [15:0] tmo_reload = '0;
    logic        io_rd = 1'b0, io_wr = 1'b0;
    logic [0:0]  io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        cpu_clk_en, int_n, nmi_n, rst_out_n;
    logic [1:0]  pwr_state;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2.0) clk = ~clk;

    pwr_wake_ctrl #(.TMO_W(16), .RST_LEN(RST_LEN), .ADDR_W(1), .DATA_W(8)) u_pwr_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .halt_n(halt_n), .kbd_scan_req(kbd_scan_req),
        .batt_low(batt_low), .flap_open(flap_open), .sense_in(sense_in), .btn_in(btn_in),
        .tmo_reload(tmo_reload), .io_rd(io_rd), .io_wr(io_wr), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .cpu_clk_en(cpu_clk_en), .int_n(int_n),
        .nmi_n(nmi_n), .rst_out_n(rst_out_n), .pwr_state(pwr_state)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic addr, output logic [7:0] data);
        io_addr = addr;
        io_rd   = 1'b1;
        #1;
        data  = io_rdata;
        io_rd = 1'b0;
    endtask

    task automatic wr_clear(input logic [7:0] mask);
        io_addr  = 1'b0;
        io_wdata = mask;
        io_wr    = 1'b1;
        tick(1);
        io_wr    = 1'b0;
    endtask

    task automatic pulse_kbd();
        kbd_scan_req = 1'b1;
        tick(1);
        kbd_scan_req = 1'b0;
    endtask

    task automatic press_btn();
        btn_in = 1'b1;
        tick(4);
        btn_in = 1'b0;
    endtask

    // Reference model of the cause register under the random operations.
    function automatic logic [7:0] model_step(input logic [7:0] m, input int op, input logic [7:0] mask);
        case (op)
            0:       return m | 8'h01;
            1:       return m | 8'h02;
            default: return m & ~(mask & 8'h1F);
        endcase
    endfunction

    function automatic logic exp_int_n(input logic [7:0] m);
        return ~(m[0] | m[1]);
    endfunction

    initial begin
        logic [7:0] d;
        logic [7:0] model;
        int low_cnt;
        bit rst_seen;

        void'($urandom(32'd20240611));
        tick(4);
        rst_n = 1'b1;
        tick(4);

        // R1: reset state
        chk("R1 pwr_state", 32'(pwr_state), 0);
        chk("R1 cpu_clk_en", 32'(cpu_clk_en), 1);
        chk("R1 int_n", 32'(int_n), 1);
        chk("R1 nmi_n", 32'(nmi_n), 1);
        chk("R1 rst_out_n", 32'(rst_out_n), 1);
        rd(1'b0, d);
        chk("R1 cause", 32'(d), 0);

        // R4 R5 R3: random maskable set/clear sequence against the model
        model = 8'h00;
        for (int i = 0; i < 60; i++) begin
            int op;
            logic [7:0] mask;
            op   = int'($urandom_range(0, 2));
            mask = 8'($urandom());
            if (op == 0) pulse_kbd();
            else if (op == 1) begin
                batt_low = 1'b1;
                tick(1);
                batt_low = 1'b0;
            end else wr_clear(mask);
            model = model_step(model, op, mask);
            tick(5);
            rd(1'b0, d);
            chk("R4/R5 random cause", 32'(d), 32'(model));
            chk("R3 random int_n", 32'(int_n), 32'(exp_int_n(model)));
        end

        // R5: set in the same cycle as its clear wins
        wr_clear(8'hFF);
        tick(2);
        io_addr = 1'b0; io_wdata = 8'h01; io_wr = 1'b1; kbd_scan_req = 1'b1;
        tick(1);
        io_wr = 1'b0; kbd_scan_req = 1'b0;
        tick(2);
        rd(1'b0, d);
        chk("R5 set beats clear", 32'(d), 32'h01);

        // R12: read data is zero without a read strobe
        io_addr = 1'b0;
        #1;
        chk("R12 rdata idle", 32'(io_rdata), 0);
        wr_clear(8'h1F);
        tick(2);

        // R2: fresh halt with no NMI enters snooze
        halt_n = 1'b0;
        tick(3);
        chk("R2 snooze state", 32'(pwr_state), 1);
        chk("R2 clock stopped", 32'(cpu_clk_en), 0);

        // R3: keyboard cause wakes snooze and asserts int_n
        pulse_kbd();
        tick(3);
        chk("R3 woken state", 32'(pwr_state), 0);
        chk("R3 clock running", 32'(cpu_clk_en), 1);
        chk("R3 int_n low", 32'(int_n), 0);
        halt_n = 1'b1;
        wr_clear(8'h1F);
        tick(2);
        chk("R3 int_n released", 32'(int_n), 1);

        // R9: button in snooze only restarts the clock
        halt_n = 1'b0;
        tick(3);
        chk("R9 pre snooze", 32'(pwr_state), 1);
        rst_seen = 1'b0;
        btn_in = 1'b1;
        for (int i = 0; i < 10; i++) begin
            tick(1);
            if (!rst_out_n) rst_seen = 1'b1;
            if (i == 3) btn_in = 1'b0;
        end
        chk("R9 snooze wake state", 32'(pwr_state), 0);
        chk("R9 no reset from snooze", 32'(rst_seen), 0);
        halt_n = 1'b1;
        tick(2);

        // R11 R6: timer expiry raises NMI once
        tmo_reload = 16'd20;
        pulse_kbd();
        wr_clear(8'h01);
        tick(8);
        chk("R11 no early expiry", 32'(nmi_n), 1);
        tick(20);
        chk("R6 nmi on timeout", 32'(nmi_n), 0);
        rd(1'b0, d);
        chk("R11 timeout cause", 32'(d), 32'h04);
        wr_clear(8'h04);
        tick(30);
        rd(1'b0, d);
        chk("R11 single expiry", 32'(d), 0);
        chk("R6 nmi held", 32'(nmi_n), 0);

        // R7: halt after NMI enters coma and releases NMI
        halt_n = 1'b0;
        tick(3);
        chk("R7 coma state", 32'(pwr_state), 2);
        chk("R7 clock stopped", 32'(cpu_clk_en), 0);
        chk("R7 nmi released", 32'(nmi_n), 1);

        // R8: coma ignores keyboard cause and timer expiry
        pulse_kbd();
        tick(30);
        chk("R8 coma holds", 32'(pwr_state), 2);
        chk("R8 no nmi in coma", 32'(nmi_n), 1);
        rd(1'b0, d);
        chk("R8 causes recorded", 32'(d), 32'h05);
        tmo_reload = 16'd0;
        pulse_kbd();

        // R8: sense rising edge leaves coma without NMI
        sense_in = 1'b1;
        tick(5);
        chk("R8 sense wake", 32'(pwr_state), 0);
        chk("R8 sense no nmi", 32'(nmi_n), 1);
        rd(1'b0, d);
        chk("R4 sense cause", 32'(d), 32'h15);
        halt_n = 1'b1;
        wr_clear(8'h1F);
        tick(2);

        // R6 R12: flap open raises NMI, level readable
        flap_open = 1'b1;
        tick(5);
        chk("R6 nmi on flap", 32'(nmi_n), 0);
        rd(1'b1, d);
        chk("R12 flap open level", 32'(d), 1);
        halt_n = 1'b0;
        tick(3);
        chk("R7 coma after flap", 32'(pwr_state), 2);

        // R8: flap close leaves coma
        flap_open = 1'b0;
        tick(5);
        chk("R8 flap close wake", 32'(pwr_state), 0);
        rd(1'b1, d);
        chk("R12 flap closed level", 32'(d), 0);
        halt_n = 1'b1;
        wr_clear(8'h1F);

        // R9: button in coma only restarts the clock
        sense_in = 1'b0;
        tick(4);
        sense_in = 1'b1;
        tick(5);
        chk("R6 nmi on sense", 32'(nmi_n), 0);
        halt_n = 1'b0;
        tick(3);
        chk("R9 pre coma", 32'(pwr_state), 2);
        rst_seen = 1'b0;
        btn_in = 1'b1;
        for (int i = 0; i < 10; i++) begin
            tick(1);
            if (!rst_out_n) rst_seen = 1'b1;
            if (i == 3) btn_in = 1'b0;
        end
        chk("R9 coma wake state", 32'(pwr_state), 0);
        chk("R9 no reset from coma", 32'(rst_seen), 0);
        halt_n = 1'b1;
        wr_clear(8'h1F);

        // R10: run-state press pulses reset and clears causes and NMI
        sense_in = 1'b0;
        tick(4);
        sense_in = 1'b1;
        tick(5);
        pulse_kbd();
        tick(2);
        chk("R10 pre nmi", 32'(nmi_n), 0);
        low_cnt = 0;
        btn_in = 1'b1;
        for (int i = 0; i < 30; i++) begin
            tick(1);
            if (!rst_out_n) low_cnt++;
            if (i == 3) btn_in = 1'b0;
        end
        chk("R10 reset length", 32'(low_cnt), RST_LEN);
        chk("R10 nmi cleared", 32'(nmi_n), 1);
        rd(1'b0, d);
        chk("R10 causes cleared", 32'(d), 0);
        chk("R10 still running", 32'(pwr_state), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule